// File: doc/BRIEF.md
# Predicate Setting Compare Unit

This block turns a four-channel single-precision ALU result into per-channel predicate bits. It also works out which channels of the temporary register an instruction may write. Each channel's result can first be clamped to the range [0, 1]. When the output modifier is off, denormal values count as zero. The unit then tests each channel against zero with a 2-bit compare code. The three colour channels share one code and the alpha channel has its own.

The 4-bit predicate register is held inside the block. A valid instruction updates only the bits its predicate write mask selects. An instruction may also request a predicated temporary write, which is allowed only while it also writes the predicate. In that case the predicate value from before the instruction masks the temporary write mask. That old value never masks the predicate write mask. The temporary write enables are combinational, so they line up with the instruction on the same cycle.

Top module: `pred_cmp_unit`

## Requirements
- R1: Compare codes on `rgb_op_i`/`alpha_op_i`: 2'b00 sets the bit when the channel is zero, 2'b01 when it is negative, 2'b10 when it is non-negative, and 2'b11 when it is non-zero. Channel k sits in `chan_i[32k+31:32k]` and drives predicate bit k: bit 3 is alpha, bit 2 red, bit 1 green, bit 0 blue.
- R2: Bits 2..0 use `rgb_op_i` and bit 3 uses `alpha_op_i`, so one instruction may apply two different compare codes.
- R3: Positive zero (0x00000000) and negative zero (0x80000000) both count as zero, and a zero channel counts as non-negative. Code 01 therefore gives 0 for either zero and code 10 gives 1.
- R4: A NaN channel (exponent all ones, mantissa non-zero) counts as non-zero. Codes 01 and 10 both give 0 for it, code 11 gives 1 and code 00 gives 0.
- R5: With `clamp_en_i` high, a non-NaN value is clamped to [0, 1] before the compare. Any negative input, including minus infinity, then compares as zero, and values above 1.0 become 1.0. A NaN passes through the clamp unchanged.
- R6: With `omod_en_i` low, a denormal (exponent 0, mantissa non-zero) compares as zero. With `omod_en_i` high, it compares as a non-zero value of its own sign.
- R7: On a rising clock edge with `valid_i` high, predicate bit k takes its compare result when `pred_wmask_i[k]` is 1 and keeps its old value otherwise. With `valid_i` low, the predicate does not change.
- R8: When `valid_i`, `pred_gate_i` and at least one bit of `pred_wmask_i` are high, `temp_we_o` equals `temp_wmask_i & pred_o`, using the predicate from before the edge. The predicate update itself is never masked by the old predicate. For example, with an old predicate of 0x7 and both masks at 0xF, `temp_we_o` is 0x7 and all four predicate bits update.
- R9: When `valid_i` is high and the R8 gating condition does not hold, `temp_we_o` equals `temp_wmask_i`. When `valid_i` is low, `temp_we_o` is 0.
- R10: While `rst_n` is low, the predicate register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | An instruction is present this cycle |
| chan_i | input | 128 | Four FP32 result channels, alpha in the top word |
| clamp_en_i | input | 1 | Clamp results to [0, 1] before the compare |
| omod_en_i | input | 1 | Output modifier on; when low, denormals compare as zero |
| rgb_op_i | input | 2 | Compare code for the red, green and blue channels |
| alpha_op_i | input | 2 | Compare code for the alpha channel |
| pred_wmask_i | input | 4 | Predicate write mask per channel |
| temp_wmask_i | input | 4 | Temporary register write mask per channel |
| pred_gate_i | input | 1 | Request a predicated temporary write |
| pred_o | output | 4 | Current predicate register |
| temp_we_o | output | 4 | Effective temporary write enables |

## Verification
Random channel values are drawn from a pool of signed zeros, denormals of both signs, NaNs, infinities, 1.0 and values above it, and fully random words. Drawing from this pool separates a sign-only test from a true zero test, and separates a correct NaN result from one that falls through to the sign bit. Clamp and output-modifier flags are toggled independently, which shows whether the clamp is applied before the compare and whether the denormal rule follows the modifier flag. Directed cases cover the mixed-code instruction, the old-predicate-of-0x7 example, a gated write with an empty predicate mask, and idle cycles. Together they tell apart masking the temporary mask from wrongly masking the predicate update.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;

    typedef enum logic [1:0] {
        CMP_ZERO    = 2'b00,
        CMP_NEG     = 2'b01,
        CMP_NONNEG  = 2'b10,
        CMP_NONZERO = 2'b11
    } cmp_op_e;

    localparam int unsigned FP_W   = 32;
    localparam int unsigned FP_EXP = 8;
    localparam int unsigned FP_MAN = FP_W - FP_EXP - 1;

endpackage

// File: rtl/fp_chan_class.sv
module fp_chan_class
    import pred_cmp_pkg::*;
#(
    parameter int unsigned DW = FP_W,
    parameter int unsigned EW = FP_EXP
) (
    input  logic [DW-1:0] val_i,
    input  logic          clamp_en_i,
    input  logic          omod_en_i,
    output logic          is_zero_o,
    output logic          is_neg_o,
    output logic          is_nan_o
);
    localparam int unsigned MW = DW - EW - 1;
    localparam logic [DW-1:0] ONE_VAL = {2'b00, {(EW-1){1'b1}}, {MW{1'b0}}};

    logic [DW-1:0] post_d;
    logic          nan_d;

    always_comb begin
        nan_d  = (&val_i[DW-2:MW]) && (|val_i[MW-1:0]);
        post_d = val_i;
        if (clamp_en_i && !nan_d) begin
            if (val_i[DW-1]) begin
                post_d = '0;
            end else if (val_i > ONE_VAL) begin
                post_d = ONE_VAL;
            end
        end
        is_nan_o  = nan_d;
        is_zero_o = (post_d[DW-2:MW] == '0) &&
                    ((post_d[MW-1:0] == '0) || !omod_en_i);
        is_neg_o  = post_d[DW-1] && !is_zero_o && !nan_d;
    end

endmodule

// File: rtl/pred_op_eval.sv
module pred_op_eval
    import pred_cmp_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic       is_zero_i,
    input  logic       is_neg_i,
    input  logic       is_nan_i,
    output logic       bit_o
);
    cmp_op_e op_d;

    always_comb begin
        op_d = cmp_op_e'(op_i);
        unique case (op_d)
            CMP_ZERO:    bit_o = is_zero_i;
            CMP_NEG:     bit_o = is_neg_i;
            CMP_NONNEG:  bit_o = !is_neg_i && !is_nan_i;
            CMP_NONZERO: bit_o = !is_zero_i;
            default:     bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pred_cmp_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = FP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [NCH*DW-1:0] chan_i,
    input  logic              clamp_en_i,
    input  logic              omod_en_i,
    input  logic [1:0]        rgb_op_i,
    input  logic [1:0]        alpha_op_i,
    input  logic [NCH-1:0]    pred_wmask_i,
    input  logic [NCH-1:0]    temp_wmask_i,
    input  logic              pred_gate_i,
    output logic [NCH-1:0]    pred_o,
    output logic [NCH-1:0]    temp_we_o
);
    localparam int unsigned ALPHA_IDX = NCH - 1;

    typedef struct packed {
        logic [NCH-1:0] pred;
    } state_t;

    state_t         st_d, st_q;
    logic [NCH-1:0] cmp_bit;
    logic [NCH-1:0] we_d;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        logic       z, n, q;
        logic [1:0] op;
        assign op = (k == ALPHA_IDX) ? alpha_op_i : rgb_op_i;

        fp_chan_class #(.DW(DW)) u_class (
            .val_i      (chan_i[k*DW +: DW]),
            .clamp_en_i (clamp_en_i),
            .omod_en_i  (omod_en_i),
            .is_zero_o  (z),
            .is_neg_o   (n),
            .is_nan_o   (q)
        );

        pred_op_eval u_eval (
            .op_i      (op),
            .is_zero_i (z),
            .is_neg_i  (n),
            .is_nan_i  (q),
            .bit_o     (cmp_bit[k])
        );
    end

    always_comb begin
        st_d = st_q;
        we_d = '0;
        if (valid_i) begin
            st_d.pred = (st_q.pred & ~pred_wmask_i) | (cmp_bit & pred_wmask_i);
            if (pred_gate_i && (|pred_wmask_i)) begin
                we_d = temp_wmask_i & st_q.pred;
            end else begin
                we_d = temp_wmask_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_o    = st_q.pred;
    assign temp_we_o = we_d;

endmodule

// File: rtl/pred_cmp_chk.sv
module pred_cmp_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           valid_i,
    input logic [NCH-1:0] pred_wmask_i,
    input logic [NCH-1:0] temp_wmask_i,
    input logic           pred_gate_i,
    input logic [NCH-1:0] pred_o,
    input logic [NCH-1:0] temp_we_o
);
    // R7
    masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (((pred_o ^ $past(pred_o)) & ~$past(pred_wmask_i)) == '0));

    // R7
    idle_pred_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pred_o));

    // R8
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_gate_i && (|pred_wmask_i)) |-> ((temp_we_o & ~pred_o) == '0));

    // R9
    ungated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !(pred_gate_i && (|pred_wmask_i))) |-> (temp_we_o == temp_wmask_i));

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (temp_we_o == '0));

    // R8
    we_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_we_o & ~temp_wmask_i) == '0);

endmodule

bind pred_cmp_unit pred_cmp_chk #(.NCH(NCH)) u_pred_cmp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .pred_wmask_i (pred_wmask_i),
    .temp_wmask_i (temp_wmask_i),
    .pred_gate_i  (pred_gate_i),
    .pred_o       (pred_o),
    .temp_we_o    (temp_we_o)
);

// File: tb/test_pred_cmp_unit.sv
`timescale 1ns/1ps
module test_pred_cmp_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [127:0] chan_i = '0;
    logic         clamp_en_i = 1'b0;
    logic         omod_en_i = 1'b0;
    logic [1:0]   rgb_op_i = 2'b00;
    logic [1:0]   alpha_op_i = 2'b00;
    logic [3:0]   pred_wmask_i = '0;
    logic [3:0]   temp_wmask_i = '0;
    logic         pred_gate_i = 1'b0;
    logic [3:0]   pred_o;
    logic [3:0]   temp_we_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [3:0] model_pred = '0;

    always #4 clk = ~clk;

    pred_cmp_unit i_pred_cmp_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (valid_i),
        .chan_i       (chan_i),
        .clamp_en_i   (clamp_en_i),
        .omod_en_i    (omod_en_i),
        .rgb_op_i     (rgb_op_i),
        .alpha_op_i   (alpha_op_i),
        .pred_wmask_i (pred_wmask_i),
        .temp_wmask_i (temp_wmask_i),
        .pred_gate_i  (pred_gate_i),
        .pred_o       (pred_o),
        .temp_we_o    (temp_we_o)
    );

    function automatic bit ref_cmp(logic [31:0] v, logic [1:0] op, bit clamp, bit omod);
        bit sgn, nan, zero, neg;
        sgn  = v[31];
        nan  = (v[30:23] == 8'hFF) && (v[22:0] != 0);
        zero = (v[30:23] == 8'h00) && ((v[22:0] == 0) || !omod);
        if (clamp && !nan && sgn) begin
            zero = 1'b1;
            sgn  = 1'b0;
        end
        neg = sgn && !zero && !nan;
        case (op)
            2'b00:   return zero;
            2'b01:   return neg;
            2'b10:   return !neg && !nan;
            default: return !zero;
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 10)
            0:       return 32'h0000_0000;
            1:       return 32'h8000_0000;
            2:       return {r[31], 8'h00, r[22:0] | 23'h1};
            3:       return {r[31], 8'hFF, r[22:0] | 23'h1};
            4:       return {r[31], 8'hFF, 23'h0};
            5:       return 32'h3F80_0000;
            6:       return {r[31], 31'h4000_0000};
            7:       return {1'b1, r[30:0]};
            default: return r;
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies the current inputs for one cycle and checks both outputs.
    task automatic run_instr(string tag);
        logic [3:0] nb, exp_we, exp_pred;
        for (int k = 0; k < 4; k++) begin
            nb[k] = ref_cmp(chan_i[k*32 +: 32], (k == 3) ? alpha_op_i : rgb_op_i,
                            clamp_en_i, omod_en_i);
        end
        if (!valid_i) exp_we = 4'h0;
        else if (pred_gate_i && pred_wmask_i != 0) exp_we = temp_wmask_i & model_pred;
        else exp_we = temp_wmask_i;
        exp_pred = valid_i ? ((model_pred & ~pred_wmask_i) | (nb & pred_wmask_i)) : model_pred;
        #2;
        check({tag, " temp_we"}, temp_we_o, exp_we);
        @(negedge clk);
        model_pred = exp_pred;
        check({tag, " pred"}, pred_o, exp_pred);
    endtask

    task automatic set_instr(logic [31:0] a, logic [31:0] r, logic [31:0] g, logic [31:0] b,
                             logic [1:0] rop, logic [1:0] aop, logic [3:0] pwm,
                             logic [3:0] twm, bit gate, bit clamp, bit omod);
        valid_i = 1'b1;
        chan_i = {a, r, g, b};
        rgb_op_i = rop;
        alpha_op_i = aop;
        pred_wmask_i = pwm;
        temp_wmask_i = twm;
        pred_gate_i = gate;
        clamp_en_i = clamp;
        omod_en_i = omod;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset", pred_o, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", pred_o, 4'h0);

        // R1 R2: zero tests on rgb, non-zero on alpha
        set_instr(32'h3F80_0000, 32'h0, 32'h4000_0000, 32'h0, 2'b00, 2'b11, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1);
        run_instr("R1 R2 mixed ops");
        check("R1 R2 literal", pred_o, 4'b1101);
        // R3: signed zeros under LT and GE
        set_instr(32'h8000_0000, 32'h0, 32'h8000_0000, 32'hBF80_0000, 2'b01, 2'b10, 4'hF, 4'h0, 1'b0, 1'b0, 1'b1);
        run_instr("R3 zero is non-negative");
        check("R3 literal", pred_o, 4'b1001);
        // R4: NaN under each code
        for (int op = 0; op < 4; op++) begin
            set_instr(32'hFFC0_0001, 32'h7FC0_0000, 32'h7F80_0001, 32'hFFFF_FFFF,
                      2'(op), 2'(op), 4'hF, 4'hF, 1'b0, 1'b1, 1'b1);
            run_instr("R4 NaN");
        end
        // R5: clamp turns negatives into zero
        set_instr(32'hFF80_0000, 32'hBF80_0000, 32'h4100_0000, 32'h8000_0001, 2'b00, 2'b00, 4'hF, 4'hF, 1'b0, 1'b1, 1'b1);
        run_instr("R5 clamp");
        check("R5 literal", pred_o, 4'b1101);
        // R6: denormals with modifier off and on
        set_instr(32'h0000_0001, 32'h8000_0010, 32'h0040_0000, 32'h8000_0001, 2'b01, 2'b11, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
        run_instr("R6 denorm flush");
        check("R6 literal flush", pred_o, 4'b0000);
        set_instr(32'h0000_0001, 32'h8000_0010, 32'h0040_0000, 32'h8000_0001, 2'b01, 2'b11, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1);
        run_instr("R6 denorm kept");
        check("R6 literal kept", pred_o, 4'b1101);
        // R8: old predicate 0x7 example
        set_instr(32'h3F80_0000, 32'h0, 32'h0, 32'h0, 2'b00, 2'b00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1);
        run_instr("R8 setup");
        set_instr(32'h0, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 2'b00, 2'b00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1);
        #2;
        check("R8 example temp_we", temp_we_o, 4'h7);
        @(negedge clk);
        model_pred = 4'h8;
        check("R8 example pred", pred_o, 4'h8);
        // R9: gate with empty predicate mask is not gated
        set_instr(32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 2'b00, 4'h0, 4'hB, 1'b1, 1'b0, 1'b1);
        run_instr("R9 gate without pred write");
        // R7 R9: idle cycle
        valid_i = 1'b0;
        run_instr("R7 R9 idle");
        // R7: partial mask
        set_instr(32'h0, 32'h0, 32'h0, 32'h0, 2'b00, 2'b00, 4'h5, 4'h0, 1'b0, 1'b0, 1'b1);
        run_instr("R7 partial mask");

        for (int i = 0; i < 400; i++) begin
            set_instr(pick_val(), pick_val(), pick_val(), pick_val(),
                      2'($urandom), 2'($urandom), 4'($urandom), 4'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
            valid_i = ($urandom % 8) != 0;
            run_instr("R1 R2 R7 R8 R9 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule